// File: doc/BRIEF.md
# Clock-Calendar Counter with Alarm

This block keeps wall-clock time and calendar date in one packed 32-bit word. The word holds seconds, minutes, hours, day of month, month and a 6-bit year offset. The word advances by one second on each rising edge of a slow count tick, nominally 1 Hz, and only while the block is enabled. Software reads the word directly and may overwrite it at any time. It also programs a 32-bit alarm word and a mode/control set: a 12-or-24-hour selector, a field-mask selector and a clear-on-match option.

Every year offset divisible by four is treated as a leap year, so offset 0 must correspond to a leap year. After the last second of December 31 of year 63, the calendar wraps to the start value and raises an overflow flag. An alarm flag is raised on the tick that follows a period in which the clock matched the alarm in the selected fields. When clear-on-match is enabled, that same tick resets the calendar and raises overflow as well. Both flags are cleared by writing ones.

Top module: `rtc_calendar`

## Requirements
- R1: The calendar advances by one second only on a clock cycle where `tick` is high after having been low in the previous cycle, and only while `run_en` is high. A tick held high advances the calendar once. With `run_en` low, the value does not change.
- R2: After reset:
  - the value is `0x00420000`, which is 00:00:00 on day 1, month 1, year 0 in 24-hour form;
  - both flags are 0;
  - 24-hour mode is selected.
- R3: Word layout is seconds [5:0], minutes [11:6], hours [16:12], day [21:17], month [25:22] (1 = January) and year [31:26]. Seconds carry at 59, minutes carry at 59, and in 24-hour mode hours run 0 to 23 and carry into the day.
- R4: In 12-hour mode, bits [15:12] hold the hour 1 to 12 and bit 16 is the PM marker. The sequence is:
  - 11 AM is followed by 12 PM, and 12 is followed by 1;
  - 11 PM is followed by 12 AM of the next day.
  The start value in this mode has hour field 12 with the PM marker clear (`0x0042C000`).
- R5: Months have their usual lengths: 30 for April, June, September and November, and 31 for the others. February has 29 days when the year offset is divisible by 4 and 28 otherwise. December carries into the next year.
- R6: The tick that finds the value at 23:59:59 on December 31 of year 63 loads the start value and sets the overflow flag.
- R7: `cfg_hour12` is stored on a `cfg_wr` cycle only when `run_en` is low. While enabled, the mode bit is unchanged. `cfg_mclr` and `cfg_msel` are stored on every `cfg_wr`.
- R8: The mask selector compares a low slice of the value with the same slice of the alarm word:
  - 0: no alarm;
  - 1: seconds only;
  - 2: up to minutes;
  - 3: up to hours;
  - 4: up to day;
  - 5: up to month;
  - 6: the full word;
  - 7: no alarm.
- R9: The alarm flag is set on the advancing tick at which the current value matches. A value that becomes a match on a tick therefore flags on the following tick.
- R10: With clear-on-match set, an advancing tick at a match loads the start value and sets both the alarm flag and the overflow flag.
- R11: Writing 1 to `flag_clr[0]` clears the alarm flag and writing 1 to `flag_clr[1]` clears the overflow flag. A flag set by a tick in the same cycle stays set.
- R12: A `time_wr` in the same cycle as an advancing tick loads `time_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Counter enable |
| tick | input | 1 | Count tick level, rising edge advances |
| cfg_wr | input | 1 | Control write strobe |
| cfg_hour12 | input | 1 | 1 selects 12-hour mode |
| cfg_mclr | input | 1 | Clear-on-match enable |
| cfg_msel | input | 3 | Alarm field mask selector |
| time_wr | input | 1 | Calendar write strobe |
| time_wdata | input | 32 | Calendar write value |
| alarm_wr | input | 1 | Alarm write strobe |
| alarm_wdata | input | 32 | Alarm write value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 alarm, bit 1 overflow |
| time_value | output | 32 | Current calendar word |
| alarm_flag | output | 1 | Alarm flag |
| ovf_flag | output | 1 | Overflow flag |
| hour12_mode | output | 1 | Current hour mode |

## Verification
Assertions check several rules on every cycle:
- the value stays unchanged while the block is disabled and not written;
- a software write lands exactly in the next cycle;
- the mode bit stays unchanged when it is written while enabled;
- a wrap or a clear-on-match always leaves the expected flags set.

Carry chains need directed scenarios, because they span many fields: the 12-hour AM/PM sequence, month lengths and leap Februaries. The same applies to the one-tick alarm lag and to each mask selection against deliberately differing fields.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 6;
    localparam int SEL_W  = 3;
    localparam int WORD_W = SEC_W + MIN_W + HR_W + DAY_W + MON_W + YR_W;
    localparam int MIN_LO = SEC_W;
    localparam int HR_LO  = MIN_LO + MIN_W;
    localparam int DAY_LO = HR_LO + HR_W;
    localparam int MON_LO = DAY_LO + DAY_W;
    localparam int YR_LO  = MON_LO + MON_W;

    typedef struct packed {
        logic [YR_W-1:0]  year;
        logic [MON_W-1:0] month;
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hour;
        logic [MIN_W-1:0] minute;
        logic [SEC_W-1:0] second;
    } cal_t;

    function automatic cal_t cal_start(input logic h12);
        cal_t c;
        c        = '0;
        c.day    = DAY_W'(1);
        c.month  = MON_W'(1);
        c.hour   = h12 ? HR_W'(12) : HR_W'(0);
        return c;
    endfunction

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic [YR_W-1:0] yr);
        logic [DAY_W-1:0] n;
        case (mon)
            MON_W'(2):  n = (yr[1:0] == 2'b00) ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): n = DAY_W'(30);
            default:    n = DAY_W'(31);
        endcase
        return n;
    endfunction

    function automatic int sel_width(input logic [SEL_W-1:0] sel);
        int w;
        case (sel)
            SEL_W'(1): w = MIN_LO;
            SEL_W'(2): w = HR_LO;
            SEL_W'(3): w = DAY_LO;
            SEL_W'(4): w = MON_LO;
            SEL_W'(5): w = YR_LO;
            SEL_W'(6): w = WORD_W;
            default:   w = 0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/rtc_tick_edge.sv
module rtc_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_en,
    output logic adv
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = tick;
        adv    = run_en & tick & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  cal_t cur,
    input  logic hour12,
    output cal_t nxt,
    output logic wrapped
);
    logic             c_min, c_hr, c_day, c_mon, c_yr;
    logic [3:0]       h;
    logic             pm;
    logic [DAY_W-1:0] dim;

    always_comb begin
        nxt   = cur;
        h     = cur.hour[3:0];
        pm    = cur.hour[4];
        dim   = month_len(cur.month, cur.year);
        c_min = (cur.second == SEC_W'(59));
        c_hr  = c_min && (cur.minute == MIN_W'(59));
        c_day = c_hr && (hour12 ? (h == 4'd11 && pm) : (cur.hour == HR_W'(23)));
        c_mon = c_day && (cur.day == dim);
        c_yr  = c_mon && (cur.month == MON_W'(12));

        nxt.second = c_min ? '0 : cur.second + SEC_W'(1);
        if (c_min) nxt.minute = c_hr ? '0 : cur.minute + MIN_W'(1);
        if (c_hr) begin
            if (hour12) begin
                if (h == 4'd11)      nxt.hour = {~pm, 4'd12};
                else if (h == 4'd12) nxt.hour = {pm, 4'd1};
                else                 nxt.hour = {pm, h + 4'd1};
            end else begin
                nxt.hour = c_day ? '0 : cur.hour + HR_W'(1);
            end
        end
        if (c_day) nxt.day   = c_mon ? DAY_W'(1) : cur.day + DAY_W'(1);
        if (c_mon) nxt.month = c_yr ? MON_W'(1) : cur.month + MON_W'(1);
        if (c_yr)  nxt.year  = cur.year + YR_W'(1);
        wrapped = c_yr && (cur.year == {YR_W{1'b1}});
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] alarm,
    input  logic [SEL_W-1:0]  sel,
    output logic              match
);
    logic [WORD_W-1:0] mask;
    int                width;

    always_comb begin
        width = sel_width(sel);
        for (int i = 0; i < WORD_W; i++) mask[i] = (i < width);
        match = (width != 0) && (((cur ^ alarm) & mask) == '0);
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic              cfg_hour12,
    input  logic              cfg_mclr,
    input  logic [SEL_W-1:0]  cfg_msel,
    input  logic              time_wr,
    input  logic [WORD_W-1:0] time_wdata,
    input  logic              alarm_wr,
    input  logic [WORD_W-1:0] alarm_wdata,
    input  logic [1:0]        flag_clr,
    output logic [WORD_W-1:0] time_value,
    output logic              alarm_flag,
    output logic              ovf_flag,
    output logic              hour12_mode
);
    typedef struct packed {
        cal_t              cal;
        logic [WORD_W-1:0] alarm;
        logic              hour12;
        logic              mclr;
        logic [SEL_W-1:0]  msel;
        logic              aflag;
        logic              oflag;
    } state_t;

    state_t s_d, s_q;
    logic   adv, match, wrapped;
    cal_t   cal_nxt;

    rtc_tick_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run_en (run_en),
        .adv    (adv)
    );

    rtc_advance i_adv (
        .cur     (s_q.cal),
        .hour12  (s_q.hour12),
        .nxt     (cal_nxt),
        .wrapped (wrapped)
    );

    rtc_alarm_cmp i_cmp (
        .cur   (s_q.cal),
        .alarm (s_q.alarm),
        .sel   (s_q.msel),
        .match (match)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            s_d.mclr = cfg_mclr;
            s_d.msel = cfg_msel;
            if (!run_en) s_d.hour12 = cfg_hour12;
        end
        if (alarm_wr)    s_d.alarm = alarm_wdata;
        if (flag_clr[0]) s_d.aflag = 1'b0;
        if (flag_clr[1]) s_d.oflag = 1'b0;
        if (adv) begin
            if (match) s_d.aflag = 1'b1;
            if (match && s_q.mclr) begin
                s_d.cal   = cal_start(s_q.hour12);
                s_d.oflag = 1'b1;
            end else begin
                s_d.cal = cal_nxt;
                if (wrapped) s_d.oflag = 1'b1;
            end
        end
        if (time_wr) s_d.cal = time_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cal    <= cal_start(1'b0);
        end else begin
            s_q <= s_d;
        end
    end

    assign time_value  = s_q.cal;
    assign alarm_flag  = s_q.aflag;
    assign ovf_flag    = s_q.oflag;
    assign hour12_mode = s_q.hour12;

    p_hold_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !time_wr) |=> $stable(time_value));

    p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cfg_wr) |=> $stable(hour12_mode));

    p_wrap_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrapped && !match && !time_wr) |=> (ovf_flag && time_value[MON_LO +: MON_W] == MON_W'(1)
                                                   && time_value[DAY_LO +: DAY_W] == DAY_W'(1)));

    p_clear_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && match && s_q.mclr) |=> (alarm_flag && ovf_flag));

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> (time_value == $past(time_wdata)));
endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, tick = 1'b0;
    logic        cfg_wr = 1'b0, cfg_hour12 = 1'b0, cfg_mclr = 1'b0;
    logic [2:0]  cfg_msel = 3'd0;
    logic        time_wr = 1'b0, alarm_wr = 1'b0;
    logic [31:0] time_wdata = '0, alarm_wdata = '0;
    logic [1:0]  flag_clr = 2'b00;
    logic [31:0] time_value;
    logic        alarm_flag, ovf_flag, hour12_mode;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar i_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .cfg_wr(cfg_wr), .cfg_hour12(cfg_hour12), .cfg_mclr(cfg_mclr), .cfg_msel(cfg_msel),
        .time_wr(time_wr), .time_wdata(time_wdata), .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata),
        .flag_clr(flag_clr), .time_value(time_value), .alarm_flag(alarm_flag),
        .ovf_flag(ovf_flag), .hour12_mode(hour12_mode)
    );

    function automatic logic [31:0] tv(int y, int mo, int d, int h, int mi, int s);
        logic [31:0] w;
        w = {y[5:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_time(logic [31:0] v);
        @(negedge clk); time_wr = 1'b1; time_wdata = v;
        @(negedge clk); time_wr = 1'b0;
    endtask

    task automatic write_alarm(logic [31:0] v);
        @(negedge clk); alarm_wr = 1'b1; alarm_wdata = v;
        @(negedge clk); alarm_wr = 1'b0;
    endtask

    task automatic set_cfg(logic h12, logic mc, logic [2:0] sel);
        @(negedge clk); cfg_wr = 1'b1; cfg_hour12 = h12; cfg_mclr = mc; cfg_msel = sel;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 2'b11;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic step_check(string tag, logic [31:0] from, logic [31:0] to);
        write_time(from);
        tick_once();
        check(tag, time_value, to);
    endtask

    task automatic t_reset();
        check("R2 value", time_value, 32'h0042_0000);
        check("R2 flags", {alarm_flag, ovf_flag, hour12_mode}, 32'd0);
    endtask

    task automatic t_enable();
        run_en = 1'b0;
        write_time(tv(0, 1, 1, 5, 5, 5));
        tick_once();
        check("R1 disabled", time_value, tv(0, 1, 1, 5, 5, 5));
        run_en = 1'b1;
        @(negedge clk); tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        check("R1 held tick", time_value, tv(0, 1, 1, 5, 5, 6));
    endtask

    task automatic t_carry24();
        step_check("R3 day carry", tv(0, 1, 1, 23, 59, 59), tv(0, 1, 2, 0, 0, 0));
        step_check("R3 hour carry", tv(0, 1, 1, 10, 59, 59), tv(0, 1, 1, 11, 0, 0));
    endtask

    task automatic t_hour12();
        run_en = 1'b0;
        set_cfg(1'b1, 1'b0, 3'd0);
        check("R7 set when off", {31'd0, hour12_mode}, 32'd1);
        run_en = 1'b1;
        step_check("R4 11AM to 12PM", tv(0, 1, 1, 11, 59, 59), tv(0, 1, 1, 12 + 16, 0, 0));
        step_check("R4 12PM to 1PM", tv(0, 1, 1, 12 + 16, 59, 59), tv(0, 1, 1, 1 + 16, 0, 0));
        step_check("R4 11PM to 12AM", tv(0, 1, 1, 11 + 16, 59, 59), tv(0, 1, 2, 12, 0, 0));
        set_cfg(1'b0, 1'b0, 3'd0);
        check("R7 locked when on", {31'd0, hour12_mode}, 32'd1);
        step_check("R4 12h wrap start", tv(63, 12, 31, 11 + 16, 59, 59), 32'h0042_C000);
        run_en = 1'b0;
        set_cfg(1'b0, 1'b0, 3'd0);
        check("R7 cleared when off", {31'd0, hour12_mode}, 32'd0);
        clear_flags();
        run_en = 1'b1;
    endtask

    task automatic t_months();
        step_check("R5 feb common", tv(1, 2, 28, 23, 59, 59), tv(1, 3, 1, 0, 0, 0));
        step_check("R5 feb leap", tv(4, 2, 28, 23, 59, 59), tv(4, 2, 29, 0, 0, 0));
        step_check("R5 feb 29 end", tv(4, 2, 29, 23, 59, 59), tv(4, 3, 1, 0, 0, 0));
        step_check("R5 april", tv(2, 4, 30, 23, 59, 59), tv(2, 5, 1, 0, 0, 0));
        step_check("R5 january", tv(2, 1, 31, 23, 59, 59), tv(2, 2, 1, 0, 0, 0));
        step_check("R5 new year", tv(5, 12, 31, 23, 59, 59), tv(6, 1, 1, 0, 0, 0));
        check("R6 no ovf early", {31'd0, ovf_flag}, 32'd0);
    endtask

    task automatic t_wrap();
        step_check("R6 wrap value", tv(63, 12, 31, 23, 59, 59), 32'h0042_0000);
        check("R6 ovf set", {31'd0, ovf_flag}, 32'd1);
        @(negedge clk); flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        check("R11 ovf cleared", {31'd0, ovf_flag}, 32'd0);
        write_time(tv(63, 12, 31, 23, 59, 59));
        @(negedge clk); tick = 1'b1; flag_clr = 2'b10;
        @(negedge clk); tick = 1'b0; flag_clr = 2'b00;
        check("R11 set wins", {31'd0, ovf_flag}, 32'd1);
        clear_flags();
    endtask

    task automatic t_alarm();
        set_cfg(1'b0, 1'b0, 3'd1);
        write_alarm(tv(9, 9, 9, 9, 9, 5));
        step_check("R9 reach match", tv(0, 1, 1, 0, 1, 4), tv(0, 1, 1, 0, 1, 5));
        check("R9 no flag yet", {31'd0, alarm_flag}, 32'd0);
        tick_once();
        check("R9 flag next tick", {31'd0, alarm_flag}, 32'd1);
        clear_flags();
        check("R11 alarm cleared", {31'd0, alarm_flag}, 32'd0);
        set_cfg(1'b0, 1'b0, 3'd0);
        step_check("R8 sel0 step", tv(0, 1, 1, 0, 1, 5), tv(0, 1, 1, 0, 1, 6));
        check("R8 sel0 no alarm", {31'd0, alarm_flag}, 32'd0);
        write_alarm(tv(1, 2, 3, 10, 20, 30));
        set_cfg(1'b0, 1'b0, 3'd3);
        step_check("R8 sel3 step", tv(1, 2, 9, 10, 20, 30), tv(1, 2, 9, 10, 20, 31));
        check("R8 sel3 day ignored", {31'd0, alarm_flag}, 32'd1);
        clear_flags();
        set_cfg(1'b0, 1'b0, 3'd4);
        write_time(tv(1, 2, 9, 10, 20, 30));
        tick_once();
        check("R8 sel4 day differs", {31'd0, alarm_flag}, 32'd0);
        set_cfg(1'b0, 1'b0, 3'd5);
        write_time(tv(7, 2, 3, 10, 20, 30));
        tick_once();
        check("R8 sel5 year ignored", {31'd0, alarm_flag}, 32'd1);
        clear_flags();
        set_cfg(1'b0, 1'b0, 3'd6);
        write_time(tv(7, 2, 3, 10, 20, 30));
        tick_once();
        check("R8 sel6 year differs", {31'd0, alarm_flag}, 32'd0);
        write_time(tv(1, 2, 3, 10, 20, 30));
        tick_once();
        check("R8 sel6 full match", {31'd0, alarm_flag}, 32'd1);
        clear_flags();
    endtask

    task automatic t_clear_match();
        set_cfg(1'b0, 1'b1, 3'd1);
        write_alarm(tv(0, 1, 1, 0, 0, 7));
        step_check("R10 cleared value", tv(3, 5, 6, 7, 3, 7), 32'h0042_0000);
        check("R10 both flags", {30'd0, alarm_flag, ovf_flag}, 32'd3);
        clear_flags();
        set_cfg(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_priority();
        @(negedge clk); tick = 1'b1; time_wr = 1'b1; time_wdata = tv(2, 3, 4, 5, 6, 7);
        @(negedge clk); tick = 1'b0; time_wr = 1'b0;
        check("R12 write wins", time_value, tv(2, 3, 4, 5, 6, 7));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_carry24();
        t_hour12();
        t_months();
        t_wrap();
        t_alarm();
        t_clear_match();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule